// File: doc/BRIEF.md
# Register Result Reorder Buffer

This block holds a small ring of result slots so that instructions can finish in any order and still retire in program order. The issue side takes the next free slot and records its destination register, whether the result is wanted, and whether the instruction is already known to fault. The index of that slot travels with the instruction. Several completion ports can later write a result, together with an abort indication, into any slot that is still allocated.

The retire side looks only at the oldest slot. Once that slot is filled, the block does one of three things: it writes a wanted result to the register file, it drops an unwanted result, or it raises an exact exception. An exception discards the faulting slot and every younger slot. The block reports the faulting slot index so that execution can restart from that point.

A combinational forwarding port returns the newest value of a requested register. Retiring a slot frees it but keeps its data, so a retired value can still be forwarded until the slot is allocated again.

Top module: `rob_core`

## Requirements
- R1: `issue_idx_o` shows the slot that the next issue takes. An issue is accepted when `issue_valid_i` and `issue_ready_o` are both high, and slot numbers advance by one modulo DEPTH. `issue_ready_o` is low while all DEPTH slots are allocated and during an exception cycle.
- R2: Completion port p writes `cmp_data_i[p*DATA_W +: DATA_W]` into the allocated slot `cmp_idx_i[p*IDX_W +: IDX_W]`. Ports may write different slots in the same cycle, in any order relative to program order.
- R3: Retirement waits for the oldest slot to be filled and retires one slot per cycle in program order. For a wanted, non-faulting slot, `ret_valid_o` is high together with its `ret_dst_o` and `ret_data_o` in the cycle after the fill edge.
- R4: An unwanted slot is freed at retirement with `ret_valid_o` held low.
- R5: When the oldest filled slot carries a fault, `exc_valid_o` is high and `exc_idx_o` names that slot. The fault comes from `issue_exc_i` at issue or from `cmp_abort_i` at completion. No register write occurs, the faulting slot and all younger slots are discarded, and the next issue reuses the faulting slot index.
- R6: For `fwd_reg_i`, the newest matching slot decides the forwarding result. If that slot is filled and not faulting, `fwd_hit_o` is high and `fwd_data_o` carries its value. Otherwise `fwd_stall_o` is high.
- R7: A wanted slot that has retired stays visible to forwarding, at lower priority than allocated slots, until it is allocated again.
- R8: A completion write to an unallocated slot has no effect on the stored state and raises `wr_err_o` in the same cycle.
- R9: After reset the buffer is empty: `issue_ready_o` is 1, `issue_idx_o` is 0, and `ret_valid_o`, `exc_valid_o`, `fwd_hit_o` and `fwd_stall_o` are 0.
- R10: Discarded slots and retired unwanted slots never produce a forwarding hit or stall.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| issue_valid_i | input | 1 | Issue request |
| issue_dst_i | input | REG_W | Destination register of the issuing instruction |
| issue_wanted_i | input | 1 | Result must reach the register file |
| issue_exc_i | input | 1 | Instruction already faulting; slot is filled at issue |
| issue_ready_o | output | 1 | Issue can be accepted this cycle |
| issue_idx_o | output | IDX_W | Slot index assigned to the next issue |
| cmp_valid_i | input | N_WR | Per-port completion strobe |
| cmp_idx_i | input | N_WR*IDX_W | Per-port target slot |
| cmp_data_i | input | N_WR*DATA_W | Per-port result value |
| cmp_abort_i | input | N_WR | Per-port abort indication |
| ret_valid_o | output | 1 | Register file write strobe |
| ret_dst_o | output | REG_W | Register file write address |
| ret_data_o | output | DATA_W | Register file write data |
| exc_valid_o | output | 1 | Exact exception this cycle |
| exc_idx_o | output | IDX_W | Faulting slot index |
| fwd_reg_i | input | REG_W | Register looked up for forwarding |
| fwd_hit_o | output | 1 | Forwarded value is valid |
| fwd_stall_o | output | 1 | Newest producer not yet usable |
| fwd_data_o | output | DATA_W | Forwarded value |
| wr_err_o | output | 1 | Completion aimed at an unallocated slot |

## Verification
All outputs are combinational functions of slot state and the current inputs. A completion written at edge t appears on the retire or exception outputs during the cycle after t, and it is visible to forwarding in that same cycle. `issue_idx_o` moves one edge after an accepted issue, and `wr_err_o` rises in the cycle of the bad write itself. The bench drives inputs at the falling edge, compares every output 1 ns later against a queue-based model in the state it holds before the coming rising edge, and advances the model at that rising edge. Each check therefore lands in exactly the cycle in which its result is due.

// File: rtl/rob_pkg.sv
package rob_pkg;
  typedef enum logic [1:0] {
    HEAD_WAIT,
    HEAD_COMMIT,
    HEAD_FREE,
    HEAD_FAULT
  } head_act_e;
endpackage

// File: rtl/rob_ptrs.sv
module rob_ptrs #(
  parameter int DEPTH = 8,
  parameter int IDX_W = $clog2(DEPTH),
  parameter int CNT_W = IDX_W + 1
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             issue_fire_i,
  input  logic             retire_fire_i,
  input  logic             flush_i,
  output logic [IDX_W-1:0] head_o,
  output logic [IDX_W-1:0] tail_o,
  output logic [CNT_W-1:0] count_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      head_o  <= '0;
      tail_o  <= '0;
      count_o <= '0;
    end else if (flush_i) begin
      // rewind allocation to the faulting slot
      tail_o  <= head_o;
      count_o <= '0;
    end else begin
      if (retire_fire_i) head_o <= head_o + 1'b1;
      if (issue_fire_i)  tail_o <= tail_o + 1'b1;
      count_o <= count_o + CNT_W'(issue_fire_i) - CNT_W'(retire_fire_i);
    end
  end
endmodule

// File: rtl/rob_slots.sv
module rob_slots #(
  parameter int DEPTH  = 8,
  parameter int REG_W  = 4,
  parameter int DATA_W = 32,
  parameter int N_WR   = 2,
  parameter int IDX_W  = $clog2(DEPTH)
) (
  input  logic                   clk_i,
  input  logic                   rst_ni,
  input  logic                   flush_i,
  input  logic                   issue_fire_i,
  input  logic [IDX_W-1:0]       tail_i,
  input  logic [REG_W-1:0]       issue_dst_i,
  input  logic                   issue_wanted_i,
  input  logic                   issue_exc_i,
  input  logic                   retire_fire_i,
  input  logic [IDX_W-1:0]       head_i,
  input  logic [N_WR-1:0]        cmp_valid_i,
  input  logic [N_WR*IDX_W-1:0]  cmp_idx_i,
  input  logic [N_WR*DATA_W-1:0] cmp_data_i,
  input  logic [N_WR-1:0]        cmp_abort_i,
  output logic [DEPTH-1:0]       alloc_o,
  output logic [DEPTH-1:0]       filled_o,
  output logic [DEPTH-1:0]       exc_o,
  output logic [DEPTH-1:0]       wanted_o,
  output logic [DEPTH-1:0]       vis_o,
  output logic [REG_W-1:0]       dst_o  [DEPTH],
  output logic [DATA_W-1:0]      data_o [DEPTH]
);
  for (genvar s = 0; s < DEPTH; s++) begin : g_slot
    logic              alloc_q, filled_q, exc_q, wanted_q, vis_q;
    logic [REG_W-1:0]  dst_q;
    logic [DATA_W-1:0] data_q;
    logic              wr_hit, wr_abort;
    logic [DATA_W-1:0] wr_data;

    always_comb begin
      wr_hit   = 1'b0;
      wr_abort = 1'b0;
      wr_data  = '0;
      for (int p = 0; p < N_WR; p++) begin
        if (cmp_valid_i[p] && cmp_idx_i[p*IDX_W +: IDX_W] == IDX_W'(s)) begin
          wr_hit   = 1'b1;
          wr_abort = cmp_abort_i[p];
          wr_data  = cmp_data_i[p*DATA_W +: DATA_W];
        end
      end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        alloc_q  <= 1'b0;
        filled_q <= 1'b0;
        exc_q    <= 1'b0;
        wanted_q <= 1'b0;
        vis_q    <= 1'b0;
        dst_q    <= '0;
        data_q   <= '0;
      end else if (flush_i) begin
        if (alloc_q) begin
          alloc_q  <= 1'b0;
          filled_q <= 1'b0;
          vis_q    <= 1'b0;
        end
      end else begin
        if (retire_fire_i && head_i == IDX_W'(s)) begin
          // free the slot, data stays for forwarding
          alloc_q <= 1'b0;
          vis_q   <= wanted_q;
        end
        if (wr_hit && alloc_q) begin
          filled_q <= 1'b1;
          data_q   <= wr_data;
          exc_q    <= exc_q | wr_abort;
        end
        if (issue_fire_i && tail_i == IDX_W'(s)) begin
          alloc_q  <= 1'b1;
          filled_q <= issue_exc_i;
          exc_q    <= issue_exc_i;
          wanted_q <= issue_wanted_i;
          vis_q    <= 1'b0;
          dst_q    <= issue_dst_i;
        end
      end
    end

    assign alloc_o[s]  = alloc_q;
    assign filled_o[s] = filled_q;
    assign exc_o[s]    = exc_q;
    assign wanted_o[s] = wanted_q;
    assign vis_o[s]    = vis_q;
    assign dst_o[s]    = dst_q;
    assign data_o[s]   = data_q;
  end
endmodule

// File: rtl/rob_fwd.sv
module rob_fwd #(
  parameter int DEPTH  = 8,
  parameter int REG_W  = 4,
  parameter int DATA_W = 32,
  parameter int IDX_W  = $clog2(DEPTH)
) (
  input  logic [IDX_W-1:0]  tail_i,
  input  logic [REG_W-1:0]  reg_i,
  input  logic [DEPTH-1:0]  alloc_i,
  input  logic [DEPTH-1:0]  vis_i,
  input  logic [DEPTH-1:0]  filled_i,
  input  logic [DEPTH-1:0]  exc_i,
  input  logic [REG_W-1:0]  dst_i  [DEPTH],
  input  logic [DATA_W-1:0] data_i [DEPTH],
  output logic              hit_o,
  output logic              stall_o,
  output logic [DATA_W-1:0] data_o
);
  // walk from newest allocation back through retired slots
  always_comb begin
    logic             found;
    logic [IDX_W-1:0] s;
    found   = 1'b0;
    hit_o   = 1'b0;
    stall_o = 1'b0;
    data_o  = '0;
    s       = '0;
    for (int k = 1; k <= DEPTH; k++) begin
      s = tail_i - IDX_W'(k);
      if (!found && (alloc_i[s] || vis_i[s]) && dst_i[s] == reg_i) begin
        found = 1'b1;
        if (filled_i[s] && !exc_i[s]) begin
          hit_o  = 1'b1;
          data_o = data_i[s];
        end else begin
          stall_o = 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/rob_core.sv
module rob_core #(
  parameter int DEPTH  = 8,
  parameter int REG_W  = 4,
  parameter int DATA_W = 32,
  parameter int N_WR   = 2,
  parameter int IDX_W  = $clog2(DEPTH)
) (
  input  logic                   clk_i,
  input  logic                   rst_ni,
  input  logic                   issue_valid_i,
  input  logic [REG_W-1:0]       issue_dst_i,
  input  logic                   issue_wanted_i,
  input  logic                   issue_exc_i,
  output logic                   issue_ready_o,
  output logic [IDX_W-1:0]       issue_idx_o,
  input  logic [N_WR-1:0]        cmp_valid_i,
  input  logic [N_WR*IDX_W-1:0]  cmp_idx_i,
  input  logic [N_WR*DATA_W-1:0] cmp_data_i,
  input  logic [N_WR-1:0]        cmp_abort_i,
  output logic                   ret_valid_o,
  output logic [REG_W-1:0]       ret_dst_o,
  output logic [DATA_W-1:0]      ret_data_o,
  output logic                   exc_valid_o,
  output logic [IDX_W-1:0]       exc_idx_o,
  input  logic [REG_W-1:0]       fwd_reg_i,
  output logic                   fwd_hit_o,
  output logic                   fwd_stall_o,
  output logic [DATA_W-1:0]      fwd_data_o,
  output logic                   wr_err_o
);
  import rob_pkg::*;
  localparam int CNT_W = IDX_W + 1;

  logic [IDX_W-1:0]  head, tail;
  logic [CNT_W-1:0]  count;
  logic [DEPTH-1:0]  alloc, filled, exc, wanted, vis;
  logic [REG_W-1:0]  dst  [DEPTH];
  logic [DATA_W-1:0] data [DEPTH];
  head_act_e         head_act;
  logic              issue_fire, retire_fire, flush;

  always_comb begin
    head_act = HEAD_WAIT;
    if (alloc[head] && filled[head]) begin
      if (exc[head])         head_act = HEAD_FAULT;
      else if (wanted[head]) head_act = HEAD_COMMIT;
      else                   head_act = HEAD_FREE;
    end
  end

  assign flush         = (head_act == HEAD_FAULT);
  assign retire_fire   = (head_act == HEAD_COMMIT) || (head_act == HEAD_FREE);
  assign issue_ready_o = (count != CNT_W'(DEPTH)) && !flush;
  assign issue_fire    = issue_valid_i && issue_ready_o;
  assign issue_idx_o   = tail;
  assign ret_valid_o   = (head_act == HEAD_COMMIT);
  assign ret_dst_o     = dst[head];
  assign ret_data_o    = data[head];
  assign exc_valid_o   = flush;
  assign exc_idx_o     = head;

  always_comb begin
    wr_err_o = 1'b0;
    for (int p = 0; p < N_WR; p++)
      if (cmp_valid_i[p] && !alloc[cmp_idx_i[p*IDX_W +: IDX_W]]) wr_err_o = 1'b1;
  end

  rob_ptrs #(.DEPTH(DEPTH), .IDX_W(IDX_W), .CNT_W(CNT_W)) u_ptrs (
    .clk_i, .rst_ni,
    .issue_fire_i (issue_fire),
    .retire_fire_i(retire_fire),
    .flush_i      (flush),
    .head_o       (head),
    .tail_o       (tail),
    .count_o      (count)
  );

  rob_slots #(.DEPTH(DEPTH), .REG_W(REG_W), .DATA_W(DATA_W), .N_WR(N_WR), .IDX_W(IDX_W)) u_slots (
    .clk_i, .rst_ni,
    .flush_i       (flush),
    .issue_fire_i  (issue_fire),
    .tail_i        (tail),
    .issue_dst_i   (issue_dst_i),
    .issue_wanted_i(issue_wanted_i),
    .issue_exc_i   (issue_exc_i),
    .retire_fire_i (retire_fire),
    .head_i        (head),
    .cmp_valid_i   (cmp_valid_i),
    .cmp_idx_i     (cmp_idx_i),
    .cmp_data_i    (cmp_data_i),
    .cmp_abort_i   (cmp_abort_i),
    .alloc_o       (alloc),
    .filled_o      (filled),
    .exc_o         (exc),
    .wanted_o      (wanted),
    .vis_o         (vis),
    .dst_o         (dst),
    .data_o        (data)
  );

  rob_fwd #(.DEPTH(DEPTH), .REG_W(REG_W), .DATA_W(DATA_W), .IDX_W(IDX_W)) u_fwd (
    .tail_i  (tail),
    .reg_i   (fwd_reg_i),
    .alloc_i (alloc),
    .vis_i   (vis),
    .filled_i(filled),
    .exc_i   (exc),
    .dst_i   (dst),
    .data_i  (data),
    .hit_o   (fwd_hit_o),
    .stall_o (fwd_stall_o),
    .data_o  (fwd_data_o)
  );
endmodule

// File: rtl/rob_core_chk.sv
module rob_core_chk #(
  parameter int DEPTH = 8,
  parameter int IDX_W = $clog2(DEPTH),
  parameter int CNT_W = IDX_W + 1
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             issue_valid_i,
  input logic             issue_ready_o,
  input logic             ret_valid_o,
  input logic             exc_valid_o,
  input logic             fwd_hit_o,
  input logic             fwd_stall_o,
  input logic [IDX_W-1:0] head,
  input logic [IDX_W-1:0] tail,
  input logic [CNT_W-1:0] count
);
  a_r1_no_overflow: assert property (@(posedge clk_i) disable iff (!rst_ni)
    count <= CNT_W'(DEPTH));
  a_r1_full_blocks: assert property (@(posedge clk_i) disable iff (!rst_ni)
    count == CNT_W'(DEPTH) |-> !issue_ready_o);
  a_r1_tail_step: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (issue_valid_i && issue_ready_o) |=> tail == IDX_W'($past(tail) + 1'b1));
  a_r3_head_step: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ret_valid_o |=> head == IDX_W'($past(head) + 1'b1));
  a_r3_one_outcome: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(ret_valid_o && exc_valid_o));
  a_r5_flush_rewinds: assert property (@(posedge clk_i) disable iff (!rst_ni)
    exc_valid_o |=> (count == '0 && tail == $past(head)));
  a_r6_hit_or_stall: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(fwd_hit_o && fwd_stall_o));
endmodule

bind rob_core rob_core_chk #(.DEPTH(DEPTH), .IDX_W(IDX_W)) u_chk (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .issue_valid_i(issue_valid_i),
  .issue_ready_o(issue_ready_o),
  .ret_valid_o  (ret_valid_o),
  .exc_valid_o  (exc_valid_o),
  .fwd_hit_o    (fwd_hit_o),
  .fwd_stall_o  (fwd_stall_o),
  .head         (head),
  .tail         (tail),
  .count        (count)
);

// File: tb/rob_core_tb_top.sv
`timescale 1ns/1ps
module rob_core_tb_top;
  localparam int DEPTH = 8, REG_W = 4, DATA_W = 32, N_WR = 2, IDX_W = 3;

  logic clk = 1'b0, rst_ni = 1'b0;
  logic issue_valid, issue_wanted, issue_exc;
  logic [REG_W-1:0] issue_dst, fwd_reg;
  logic [N_WR-1:0] cmp_valid, cmp_abort;
  logic [N_WR*IDX_W-1:0] cmp_idx;
  logic [N_WR*DATA_W-1:0] cmp_data;
  logic issue_ready_o, ret_valid_o, exc_valid_o, fwd_hit_o, fwd_stall_o, wr_err_o;
  logic [IDX_W-1:0] issue_idx_o, exc_idx_o;
  logic [REG_W-1:0] ret_dst_o;
  logic [DATA_W-1:0] ret_data_o, fwd_data_o;

  always #2 clk = ~clk;

  rob_core #(.DEPTH(DEPTH), .REG_W(REG_W), .DATA_W(DATA_W), .N_WR(N_WR)) dut_i (
    .clk_i(clk), .rst_ni(rst_ni),
    .issue_valid_i(issue_valid), .issue_dst_i(issue_dst), .issue_wanted_i(issue_wanted),
    .issue_exc_i(issue_exc), .issue_ready_o(issue_ready_o), .issue_idx_o(issue_idx_o),
    .cmp_valid_i(cmp_valid), .cmp_idx_i(cmp_idx), .cmp_data_i(cmp_data), .cmp_abort_i(cmp_abort),
    .ret_valid_o(ret_valid_o), .ret_dst_o(ret_dst_o), .ret_data_o(ret_data_o),
    .exc_valid_o(exc_valid_o), .exc_idx_o(exc_idx_o),
    .fwd_reg_i(fwd_reg), .fwd_hit_o(fwd_hit_o), .fwd_stall_o(fwd_stall_o),
    .fwd_data_o(fwd_data_o), .wr_err_o(wr_err_o)
  );

  typedef struct {
    int idx; int dst; bit wanted; bit exc; bit filled; logic [DATA_W-1:0] data;
  } ent_t;
  ent_t live[$];
  ent_t hist[$];
  int tail_m = 0;
  int checks = 0, errs = 0;
  bit done = 0;

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errs++;
      $display("FAIL %s %s act=%0h exp=%0h t=%0t", req, what, act, exp, $time);
    end
  endtask

  task automatic clr();
    issue_valid = 0; issue_dst = '0; issue_wanted = 0; issue_exc = 0;
    cmp_valid = '0; cmp_idx = '0; cmp_data = '0; cmp_abort = '0; fwd_reg = '0;
  endtask

  task automatic cmp(input int p, input int idx, input logic [DATA_W-1:0] d, input bit ab);
    cmp_valid[p] = 1'b1;
    cmp_idx[p*IDX_W +: IDX_W] = IDX_W'(idx % DEPTH);
    cmp_data[p*DATA_W +: DATA_W] = d;
    cmp_abort[p] = ab;
  endtask

  function automatic bit in_live(input int idx);
    foreach (live[i]) if (live[i].idx == idx) return 1;
    return 0;
  endfunction

  // compare all outputs against the model, then advance the model at the edge
  task automatic step();
    bit fault, rdy, rv, found, hit, err;
    string lbl;
    logic [DATA_W-1:0] fd;
    #1;
    fault = live.size() > 0 && live[0].filled && live[0].exc;
    rdy = (live.size() < DEPTH) && !fault;
    chk(issue_ready_o == rdy, fault ? "R5" : "R1", "issue_ready", issue_ready_o, rdy);
    chk(int'(issue_idx_o) == tail_m, "R1", "issue_idx", issue_idx_o, tail_m);
    rv = live.size() > 0 && live[0].filled && !live[0].exc && live[0].wanted;
    lbl = (live.size() > 0 && live[0].filled && !live[0].wanted) ? "R4" : "R3";
    chk(ret_valid_o == rv, lbl, "ret_valid", ret_valid_o, rv);
    if (rv) begin
      chk(int'(ret_dst_o) == live[0].dst, "R3", "ret_dst", ret_dst_o, live[0].dst);
      chk(ret_data_o == live[0].data, "R2", "ret_data", ret_data_o, live[0].data);
    end
    chk(exc_valid_o == fault, "R5", "exc_valid", exc_valid_o, fault);
    if (fault) chk(int'(exc_idx_o) == live[0].idx, "R5", "exc_idx", exc_idx_o, live[0].idx);
    found = 0; hit = 0; fd = '0; lbl = "R10";
    for (int i = live.size() - 1; i >= 0 && !found; i--)
      if (live[i].dst == int'(fwd_reg)) begin
        found = 1; lbl = "R6";
        hit = live[i].filled && !live[i].exc; fd = live[i].data;
      end
    for (int i = hist.size() - 1; i >= 0 && !found; i--)
      if (hist[i].dst == int'(fwd_reg)) begin
        found = 1; lbl = "R7"; hit = 1; fd = hist[i].data;
      end
    chk(fwd_hit_o == hit, lbl, "fwd_hit", fwd_hit_o, hit);
    chk(fwd_stall_o == (found && !hit), lbl, "fwd_stall", fwd_stall_o, found && !hit);
    if (hit) chk(fwd_data_o == fd, lbl, "fwd_data", fwd_data_o, fd);
    err = 0;
    for (int p = 0; p < N_WR; p++)
      if (cmp_valid[p] && !in_live(int'(cmp_idx[p*IDX_W +: IDX_W]))) err = 1;
    chk(wr_err_o == err, "R8", "wr_err", wr_err_o, err);

    @(posedge clk);
    if (fault) begin
      tail_m = live[0].idx;
      live.delete();
    end else begin
      if (live.size() > 0 && live[0].filled) begin
        if (live[0].wanted) hist.push_back(live[0]);
        void'(live.pop_front());
      end
      for (int p = 0; p < N_WR; p++)
        if (cmp_valid[p])
          for (int i = 0; i < live.size(); i++)
            if (live[i].idx == int'(cmp_idx[p*IDX_W +: IDX_W])) begin
              ent_t e = live[i];
              e.filled = 1; e.data = cmp_data[p*DATA_W +: DATA_W]; e.exc = e.exc | cmp_abort[p];
              live[i] = e;
            end
      if (issue_valid && rdy) begin
        ent_t n;
        for (int i = hist.size() - 1; i >= 0; i--) if (hist[i].idx == tail_m) hist.delete(i);
        n.idx = tail_m; n.dst = int'(issue_dst); n.wanted = issue_wanted;
        n.exc = issue_exc; n.filled = issue_exc; n.data = '0;
        live.push_back(n);
        tail_m = (tail_m + 1) % DEPTH;
      end
    end
    @(negedge clk);
  endtask

  task automatic iss(input int dst, input bit w, input bit e);
    issue_valid = 1; issue_dst = REG_W'(dst); issue_wanted = w; issue_exc = e;
    step();
    clr();
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++; errs++;
      $display("FAIL watchdog expired");
      $display("Result: errors=%0d of %0d checks", errs, checks);
      $finish;
    end
  end

  initial begin
    int b;
    clr();
    repeat (2) @(negedge clk);
    // R9 reset state
    chk(issue_ready_o == 1, "R9", "ready", issue_ready_o, 1);
    chk(issue_idx_o == 0, "R9", "idx", issue_idx_o, 0);
    chk(ret_valid_o == 0 && exc_valid_o == 0, "R9", "ret/exc", {ret_valid_o, exc_valid_o}, 0);
    chk(fwd_hit_o == 0 && fwd_stall_o == 0, "R9", "fwd", {fwd_hit_o, fwd_stall_o}, 0);
    rst_ni = 1;
    @(negedge clk);

    // R2/R3: completion out of order, two ports in one cycle
    b = tail_m;
    iss(1, 1, 0); iss(2, 1, 0); iss(3, 1, 0);
    cmp(0, b + 2, 32'hA3, 0); fwd_reg = 3; step(); clr();
    fwd_reg = 1; step(); clr();                      // R6 stall
    cmp(0, b, 32'hA1, 0); cmp(1, b + 1, 32'hA2, 0); step(); clr();
    fwd_reg = 2; repeat (4) step();
    fwd_reg = 1; step(); clr();                      // R7 retired value

    // R1 full, R4 unwanted slot
    b = tail_m;
    for (int i = 0; i < DEPTH; i++) iss(i % 4, i != 5, 0);
    issue_valid = 1; issue_dst = 9; issue_wanted = 1; step(); clr();
    fwd_reg = 2; step(); clr();
    for (int i = DEPTH - 1; i >= 0; i--) begin
      cmp(0, b + i, 32'hB0 + i, 0); fwd_reg = REG_W'(i % 4); step(); clr();
    end
    for (int i = 0; i < 10; i++) begin fwd_reg = REG_W'(i % 5); step(); end
    clr();

    // R5 abort on completion, R10 discarded slots
    b = tail_m;
    iss(5, 1, 0); iss(6, 1, 0); iss(7, 1, 0); iss(8, 1, 0);
    cmp(0, b + 2, 32'hD2, 0); cmp(1, b + 3, 32'hD3, 0); step(); clr();
    cmp(0, b, 32'hD0, 0); cmp(1, b + 1, 32'hD1, 1); step(); clr();
    fwd_reg = 7; repeat (3) step(); clr();
    iss(9, 1, 0);
    cmp(0, tail_m + DEPTH - 1, 32'hD9, 0); step(); clr();
    repeat (2) step();

    // R5 fault flagged at issue
    iss(4, 1, 1);
    fwd_reg = 4; repeat (3) step(); clr();

    // R8 write to unallocated slot
    cmp(0, tail_m, 32'hEE, 0); fwd_reg = 4; step(); clr();
    iss(4, 1, 0);
    fwd_reg = 4; step(); step(); clr();
    cmp(0, tail_m + DEPTH - 1, 32'h44, 0); step(); clr();
    repeat (2) step();

    // mixed traffic
    for (int cyc = 0; cyc < 3000; cyc++) begin
      int cand[$];
      clr();
      if ($urandom_range(99) < 60) begin
        issue_valid = 1; issue_dst = REG_W'($urandom_range(15));
        issue_wanted = ($urandom_range(99) < 80);
        issue_exc = ($urandom_range(99) < 3);
      end
      foreach (live[i]) if (!live[i].filled) cand.push_back(live[i].idx);
      for (int p = 0; p < N_WR; p++)
        if (cand.size() > 0 && $urandom_range(99) < 50) begin
          int k = $urandom_range(cand.size() - 1);
          cmp(p, cand[k], $urandom, $urandom_range(99) < 5);
          cand.delete(k);
        end
      if (!cmp_valid[0] && live.size() < DEPTH && $urandom_range(99) < 3) begin
        int st = $urandom_range(DEPTH - 1);
        for (int j = 0; j < DEPTH; j++)
          if (!cmp_valid[0] && !in_live((st + j) % DEPTH)) cmp(0, (st + j) % DEPTH, $urandom, 0);
      end
      fwd_reg = REG_W'($urandom_range(15));
      step();
    end

    done = 1;
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end
endmodule